// File: doc/BRIEF.md
# Completion Record Queue

This block keeps one completion record for each descriptor that the transfer engine finishes. A record holds the number of bytes moved, an 8-bit error code and a flag that says the transfer ended early. The engine offers records through a valid/ready handshake. When every slot is taken, ready drops and the engine waits.

The host sees only the oldest record, through a window of two read-only words. The byte count is at offset 0x0 and the status word is at offset 0x4. A read of the status word removes the record. A read of the byte count only looks at it. To advance, the host reads the byte count first and then the status word.

The block also sends its pending-record count and its empty and full flags to the control/status logic next to it.

Top module: `resp_queue`

## Requirements
- R1: After reset the queue is empty: `qEmpty`=1, `qFull`=0, `fillLevel`=0 and `pushReady`=1.
- R2: A record is stored on a clock edge where `pushValid` and `pushReady` are both high. Without a pop in the same cycle, `fillLevel` goes up by one.
- R3: While the queue holds DEPTH records, `pushReady` is low. A `pushValid` in that state stores nothing and leaves `fillLevel` at DEPTH.
- R4: A read (`rdEn`=1) at offset 0x0 returns, in the same cycle, the byte count of the oldest record, zero-extended to the data width.
- R5: A read at offset 0x4 returns, in the same cycle, the status of the oldest record: error code in bits 7:0, early-end flag in bit 8, all other bits zero.
- R6: A read at offset 0x4 removes the oldest record at the clock edge. `fillLevel` drops by one, and records leave in the order they came in.
- R7: A read at offset 0x0 never removes a record, however often it is repeated.
- R8: A read while the queue is empty returns zero at any offset, and `fillLevel` stays at zero.
- R9: `fillLevel` carries the record count. `qEmpty` is high exactly when the count is zero, and `qFull` is high exactly when the count equals DEPTH.
- R10: If a record is accepted and a record is removed in the same cycle, `fillLevel` does not change.
- R11: `rdData` is zero when `rdEn` is low or the offset is neither 0x0 nor 0x4. Such reads never remove a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Engine offers a completion record |
| pushReady | output | 1 | Queue can accept a record |
| pushBytes | input | BYTES_W | Bytes moved by the finished descriptor |
| pushErr | input | 8 | Error code of the finished descriptor |
| pushEarly | input | 1 | Descriptor ended before its full length |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | ADDR_W | Byte offset of the host read |
| rdData | output | DATA_W | Host read data (combinational) |
| fillLevel | output | FILL_W | Number of pending records |
| qEmpty | output | 1 | No record pending |
| qFull | output | 1 | DEPTH records pending |

## Verification
The bench builds the queue with DEPTH=5 and BYTES_W=16. A depth that is not a power of two selects the compare-and-wrap pointer variant. A depth of five is reached after a handful of pushes, so the full stall, repeated wrap-around and full/empty turnarounds all occur many times. The 16-bit byte count is narrower than the 32-bit read word, which exposes the zero-extension. A software model of the queue drives a long sweep of mixed pushes, peeks, pops and stray offsets, and predicts every read value and count arithmetically from each record's serial number.

// File: rtl/resp_queue_pkg.sv
package resp_queue_pkg;

  // Byte offsets inside the two-word host window
  localparam int OFS_BYTES  = 0;
  localparam int OFS_STATUS = 4;

  // Status word layout
  localparam int ERR_W     = 8;
  localparam int EARLY_BIT = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;       // write the incoming record into the tail slot
    logic pop;        // head record leaves at this edge
    logic selBytes;   // drive head byte count onto read data
    logic selStatus;  // drive head status onto read data
  } rqStrobe_t;

endpackage

// File: rtl/resp_queue_ctrl.sv
module resp_queue_ctrl
  import resp_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              pushReady,
  output rqStrobe_t         strobe,
  output logic [PTR_W-1:0]  wrIdx,
  output logic [PTR_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  count,
  output logic              isEmpty,
  output logic              isFull
);

  localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic hitBytes;
  logic hitStatus;
  logic [PTR_W-1:0] wrIdxNext;
  logic [PTR_W-1:0] rdIdxNext;

  assign isEmpty   = (count == '0);
  assign isFull    = (count == CNT_W'(DEPTH));
  assign pushReady = !isFull;

  assign hitBytes  = rdEn && (rdAddr == ADDR_W'(OFS_BYTES));
  assign hitStatus = rdEn && (rdAddr == ADDR_W'(OFS_STATUS));

  always_comb begin
    strobe           = '0;
    strobe.push      = pushValid && !isFull;
    strobe.pop       = hitStatus && !isEmpty;
    strobe.selBytes  = hitBytes && !isEmpty;
    strobe.selStatus = hitStatus && !isEmpty;
  end

  // Pointer wrap: natural rollover for power-of-two depths, compare otherwise
  generate
    if (IS_POW2) begin : g_wrapNatural
      assign wrIdxNext = wrIdx + 1'b1;
      assign rdIdxNext = rdIdx + 1'b1;
    end else begin : g_wrapCompare
      assign wrIdxNext = (wrIdx == PTR_W'(DEPTH - 1)) ? '0 : wrIdx + 1'b1;
      assign rdIdxNext = (rdIdx == PTR_W'(DEPTH - 1)) ? '0 : rdIdx + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrIdx <= wrIdxNext;
      if (strobe.pop)  rdIdx <= rdIdxNext;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/resp_queue_data.sv
module resp_queue_data
  import resp_queue_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int BYTES_W = 32,
  parameter int DATA_W  = 32,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  rqStrobe_t          strobe,
  input  logic [PTR_W-1:0]   wrIdx,
  input  logic [PTR_W-1:0]   rdIdx,
  input  logic [BYTES_W-1:0] pushBytes,
  input  logic [ERR_W-1:0]   pushErr,
  input  logic               pushEarly,
  output logic [DATA_W-1:0]  rdData
);

  logic [BYTES_W-1:0] bytesMem [DEPTH];
  logic [ERR_W-1:0]   errMem   [DEPTH];
  logic               earlyMem [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [BYTES_W-1:0] slotBytes;
      logic [ERR_W-1:0]   slotErr;
      logic               slotEarly;
      always_ff @(posedge clk) begin
        if (strobe.push && (wrIdx == PTR_W'(e))) begin
          slotBytes <= pushBytes;
          slotErr   <= pushErr;
          slotEarly <= pushEarly;
        end
      end
      assign bytesMem[e] = slotBytes;
      assign errMem[e]   = slotErr;
      assign earlyMem[e] = slotEarly;
    end
  endgenerate

  logic [BYTES_W-1:0] headBytes;
  logic [ERR_W-1:0]   headErr;
  logic               headEarly;

  assign headBytes = bytesMem[rdIdx];
  assign headErr   = errMem[rdIdx];
  assign headEarly = earlyMem[rdIdx];

  always_comb begin
    rdData = '0;
    if (strobe.selBytes) begin
      rdData = DATA_W'(headBytes);
    end else if (strobe.selStatus) begin
      rdData[ERR_W-1:0]  = headErr;
      rdData[EARLY_BIT]  = headEarly;
    end
  end

endmodule

// File: rtl/resp_queue.sv
module resp_queue
  import resp_queue_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int BYTES_W = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int FILL_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  output logic               pushReady,
  input  logic [BYTES_W-1:0] pushBytes,
  input  logic [ERR_W-1:0]   pushErr,
  input  logic               pushEarly,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [FILL_W-1:0]  fillLevel,
  output logic               qEmpty,
  output logic               qFull
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rqStrobe_t        strobe;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W-1:0] rdIdx;
  logic [CNT_W-1:0] count;

  resp_queue_ctrl #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(pushValid),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .pushReady(pushReady),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx),
    .count    (count),
    .isEmpty  (qEmpty),
    .isFull   (qFull)
  );

  resp_queue_data #(
    .DEPTH  (DEPTH),
    .BYTES_W(BYTES_W),
    .DATA_W (DATA_W)
  ) i_data (
    .clk      (clk),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .rdIdx    (rdIdx),
    .pushBytes(pushBytes),
    .pushErr  (pushErr),
    .pushEarly(pushEarly),
    .rdData   (rdData)
  );

  assign fillLevel = FILL_W'(count);

endmodule

// File: rtl/resp_queue_chk.sv
module resp_queue_chk
  import resp_queue_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int FILL_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              pushReady,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [FILL_W-1:0] fillLevel,
  input logic              qEmpty,
  input logic              qFull
);

  logic pushNow;
  logic popNow;
  assign pushNow = pushValid && pushReady;
  assign popNow  = rdEn && (rdAddr == ADDR_W'(OFS_STATUS)) && !qEmpty;

  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rstN)
    pushNow && !popNow |=> fillLevel == $past(fillLevel) + 1'b1); // R2
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !pushReady); // R3
  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    popNow && !pushNow |=> fillLevel == $past(fillLevel) - 1'b1); // R6
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (rdAddr != ADDR_W'(OFS_STATUS)) && !pushNow |=> $stable(fillLevel)); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && qEmpty |-> rdData == '0); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FILL_W'(DEPTH)); // R9
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> fillLevel == FILL_W'(DEPTH)); // R9
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pushNow && popNow |=> $stable(fillLevel)); // R10

endmodule

bind resp_queue resp_queue_chk #(
  .DEPTH (DEPTH),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .FILL_W(FILL_W)
) i_resp_queue_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pushValid(pushValid),
  .pushReady(pushReady),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .fillLevel(fillLevel),
  .qEmpty   (qEmpty),
  .qFull    (qFull)
);

// File: tb/test_resp_queue.sv
module test_resp_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 5;
  localparam int BYTES_W = 16;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int FILL_W  = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               pushValid = 1'b0;
  logic               pushReady;
  logic [BYTES_W-1:0] pushBytes = '0;
  logic [7:0]         pushErr = '0;
  logic               pushEarly = 1'b0;
  logic               rdEn = 1'b0;
  logic [ADDR_W-1:0]  rdAddr = '0;
  logic [DATA_W-1:0]  rdData;
  logic [FILL_W-1:0]  fillLevel;
  logic               qEmpty;
  logic               qFull;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Model: records identified by serial number; head/tail are serials
  int mHead = 0;
  int mTail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resp_queue #(
    .DEPTH(DEPTH), .BYTES_W(BYTES_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .FILL_W(FILL_W)
  ) i_resp_queue (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushReady(pushReady),
    .pushBytes(pushBytes), .pushErr(pushErr), .pushEarly(pushEarly),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .fillLevel(fillLevel), .qEmpty(qEmpty), .qFull(qFull)
  );

  function automatic logic [BYTES_W-1:0] bytesOf(int n);
    return BYTES_W'((n * 1237 + 91) % 65536);
  endfunction
  function automatic logic [7:0] errOf(int n);
    return 8'((n * 29 + 3) % 256);
  endfunction
  function automatic logic earlyOf(int n);
    return (n % 3) == 1;
  endfunction

  task automatic check(string tag, longint actual, longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // One cycle: inputs set just after a falling edge, outputs sampled before
  // the rising edge, count checked at the next falling edge.
  task automatic step(bit doPush, bit doRd, int addr, string fillTag);
    int cnt;
    logic [DATA_W-1:0] expData;
    string dTag;
    bit acc;
    bit pop;
    cnt = mTail - mHead;
    pushValid = doPush;
    pushBytes = bytesOf(mTail);
    pushErr   = errOf(mTail);
    pushEarly = earlyOf(mTail);
    rdEn      = doRd;
    rdAddr    = ADDR_W'(addr);
    #1;
    expData = '0;
    dTag = "R11";
    if (doRd && cnt == 0) dTag = "R8";
    else if (doRd && addr == 0) begin
      dTag = "R4"; expData = DATA_W'(bytesOf(mHead));
    end else if (doRd && addr == 4) begin
      dTag = "R5"; expData = {23'b0, earlyOf(mHead), errOf(mHead)};
    end
    check(dTag, rdData, expData);
    check(cnt == DEPTH ? "R3" : "R2", pushReady, cnt < DEPTH);
    acc = doPush && (cnt < DEPTH);
    pop = doRd && addr == 4 && cnt > 0;
    @(negedge clk);
    pushValid = 1'b0;
    rdEn = 1'b0;
    if (acc) mTail++;
    if (pop) mHead++;
    cnt = mTail - mHead;
    check(fillTag, fillLevel, cnt);
    check("R9", {qEmpty, qFull}, {cnt == 0, cnt == DEPTH});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {qEmpty, qFull, pushReady}, 3'b101);
    check("R1", fillLevel, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: empty reads return zero and do not underflow
    step(0, 1, 4, "R8");
    step(0, 1, 0, "R8");

    // R2/R3: fill to full, then push against the stall
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, "R2");
    step(1, 0, 0, "R3");
    step(1, 0, 0, "R3");

    // R7: repeated peeks keep the record; R11: stray offsets
    step(0, 1, 0, "R7");
    step(0, 1, 0, "R7");
    step(0, 1, 8, "R11");
    step(0, 1, 12, "R11");
    step(0, 0, 4, "R11");

    // R6: drain in order, reading both words
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 1, 0, "R7");
      step(0, 1, 4, "R6");
    end
    step(0, 1, 4, "R8");

    // R10: push and pop together on a partly filled queue
    step(1, 0, 0, "R2");
    step(1, 0, 0, "R2");
    step(1, 1, 4, "R10");
    step(1, 1, 4, "R10");

    // Mixed sweep over all operation patterns; wraps the pointers often
    for (int k = 0; k < 3000; k++) begin
      int sel;
      int addr;
      sel  = (k * 7 + k / 11) % 6;
      addr = ((k * 5) % 7 < 4) ? 4 : (((k * 3) % 4) * 4);
      case (sel)
        0, 1:    step(1, 0, 0, "R2");
        2:       step(0, 1, addr, addr == 4 ? "R6" : "R7");
        3:       step(1, 1, addr, "R10");
        4:       step(0, 1, 4, "R6");
        default: step(0, 0, 0, "R11");
      endcase
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule